// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block produces the one-time command train that an SDRAM needs before it can be used. Software launches it by writing a one to the initialize bit (`init_set` pulse). The block then issues a precharge of every bank, one write of the mode register, and eight auto-refresh commands. Each command is followed by a programmable run of NOP cycles. While the train runs, `cpu_stall` keeps the processor away from fetch and execution. The initialize bit, seen as `init_busy`, clears itself when the train ends. On that same cycle a one-cycle `init_done` pulse is raised and the stall is released.

The controller is a single enumerated state machine with seven states:
- `ST_IDLE`: NOP on the pins, waiting for the start bit.
- `ST_PRE`: the precharge-all command.
- `ST_PRE_WAIT`: the tRP gap.
- `ST_MRS`: the mode-register write.
- `ST_MRS_WAIT`: the tMRD gap.
- `ST_REF`: one auto-refresh.
- `ST_REF_WAIT`: the tRC gap.

The transitions are:
- start: IDLE to PRE, on `init_set`.
- issue: PRE to PRE_WAIT, MRS to MRS_WAIT and REF to REF_WAIT, always after one cycle.
- gap over: PRE_WAIT to MRS and MRS_WAIT to REF, when the gap timer expires.
- next refresh: REF_WAIT to REF, when the gap expires and fewer than eight refreshes have gone out.
- finish: REF_WAIT to IDLE, when the gap expires after the eighth refresh.

A gap timer and a refresh counter sit beside the state machine. A combinational stage maps the current command onto the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, the pins show NOP. NOP is {cs_n,ras_n,cas_n,we_n}=0111, with address 0. In the same state `init_busy`, `cpu_stall` and `init_done` are low.
- R2: An `init_set` pulse sampled while idle produces a precharge-all in the next cycle. Precharge-all is {cs_n,ras_n,cas_n,we_n}=0010, with address bit 10 high and every other address bit low.
- R3: The precharge is followed by eff(`t_rp`) NOP cycles. Then comes one mode-register write, {0000}, with `sd_addr` equal to `mode_word`.
- R4: The mode-register write is followed by eff(`t_mrd`) NOP cycles. Then comes the first auto-refresh, {0001}, with address 0.
- R5: Exactly eight auto-refreshes are issued. Each one is followed by eff(`t_rc`) NOP cycles.
- R6: eff(t) equals t for t of 1 or more. A programmed value of 0 gives one NOP cycle.
- R7: `cpu_stall` and `init_busy` are high from the cycle of the precharge through the last NOP cycle of the final tRC gap.
- R8: In the cycle after that last NOP, `init_done` is high for exactly one cycle. In that same cycle `init_busy` and `cpu_stall` are low.
- R9: `init_set` sampled while the train runs has no effect. The command trace and its timing are unchanged, and no second train follows.
- R10: `sd_cke`, `sd_udqm` and `sd_ldqm` are high in every cycle out of reset.
- R11: `init_set` sampled in the `init_done` cycle starts a new train, with a precharge in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_set | input | 1 | Software write of one to the initialize bit |
| mode_word | input | 12 | Mode register value (burst length, CAS latency, burst type) |
| t_rp | input | 4 | NOP cycles after precharge |
| t_mrd | input | 4 | NOP cycles after mode write |
| t_rc | input | 4 | NOP cycles after each refresh |
| init_busy | output | 1 | Initialize bit, cleared by hardware at the end |
| cpu_stall | output | 1 | Holds the processor off the bus |
| init_done | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_udqm | output | 1 | Upper data mask |
| sd_ldqm | output | 1 | Lower data mask |
| sd_addr | output | 12 | SDRAM address bus |

## Verification
The completion pulse and a fresh start request can land in the same cycle. At that point the machine has just re-entered idle, so the request must be honoured, not lost. The bench provokes this by driving `init_set` exactly in the cycle that should carry `init_done`. It then requires a precharge in the following cycle and a full second trace. A request placed mid-train is also checked: the cycle-accurate trace must not shift, and no extra precharge may appear.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_REF,
        ST_REF_WAIT
    } init_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_MRS,
        CMD_REF
    } init_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

endpackage

// File: rtl/sdi_gap_timer.sv
module sdi_gap_timer #(
    parameter int T_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [T_W-1:0] load_val,
    input  logic           run,
    output logic           expired
);
    logic [T_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdi_ref_counter.sv
module sdi_ref_counter #(
    parameter int N_REF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int RC_W = (N_REF > 1) ? $clog2(N_REF) : 1;

    logic [RC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == RC_W'(N_REF - 1));
endmodule

// File: rtl/sdi_cmd_drive.sv
module sdi_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  init_cmd_e          cmd,
    input  logic [ADDR_W-1:0]  mode_word,
    output cmd_pins_t          pins,
    output logic [ADDR_W-1:0]  addr
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    always_comb begin
        unique case (cmd)
            CMD_PRE: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                addr = ALL_BANKS;
            end
            CMD_MRS: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                addr = mode_word;
            end
            CMD_REF: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
                addr = '0;
            end
            default: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
                addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int T_W    = 4,
    parameter int N_REF  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_set,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic [T_W-1:0]    t_rp,
    input  logic [T_W-1:0]    t_mrd,
    input  logic [T_W-1:0]    t_rc,
    output logic              init_busy,
    output logic              cpu_stall,
    output logic              init_done,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic              sd_udqm,
    output logic              sd_ldqm,
    output logic [ADDR_W-1:0] sd_addr
);
    init_state_e     state_q, state_d;
    init_cmd_e       cmd;
    cmd_pins_t       pins;
    logic            done_q;
    logic            gap_load, gap_run, gap_over;
    logic [T_W-1:0]  gap_val;
    logic            ref_last;

    // Gap length minus one; a programmed zero still gives one NOP cycle.
    function automatic logic [T_W-1:0] gap_m1(input logic [T_W-1:0] t);
        return (t == '0) ? '0 : t - 1'b1;
    endfunction

    always_comb begin
        unique case (state_q)
            ST_PRE:  gap_val = gap_m1(t_rp);
            ST_MRS:  gap_val = gap_m1(t_mrd);
            default: gap_val = gap_m1(t_rc);
        endcase
    end

    assign gap_load = (state_q == ST_PRE) || (state_q == ST_MRS) || (state_q == ST_REF);
    assign gap_run  = (state_q == ST_PRE_WAIT) || (state_q == ST_MRS_WAIT) ||
                      (state_q == ST_REF_WAIT);

    sdi_gap_timer #(.T_W(T_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .run      (gap_run),
        .expired  (gap_over)
    );

    sdi_ref_counter #(.N_REF(N_REF)) u_refs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_PRE),
        .inc   ((state_q == ST_REF_WAIT) && gap_over && !ref_last),
        .last  (ref_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (init_set) state_d = ST_PRE;
            ST_PRE:      state_d = ST_PRE_WAIT;
            ST_PRE_WAIT: if (gap_over) state_d = ST_MRS;
            ST_MRS:      state_d = ST_MRS_WAIT;
            ST_MRS_WAIT: if (gap_over) state_d = ST_REF;
            ST_REF:      state_d = ST_REF_WAIT;
            ST_REF_WAIT: if (gap_over) state_d = ref_last ? ST_IDLE : ST_REF;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_REF_WAIT) && gap_over && ref_last;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_PRE:  cmd = CMD_PRE;
            ST_MRS:  cmd = CMD_MRS;
            ST_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
        init_busy = (state_q != ST_IDLE);
        cpu_stall = (state_q != ST_IDLE);
        init_done = done_q;
        sd_cke    = 1'b1;
        sd_udqm   = 1'b1;
        sd_ldqm   = 1'b1;
    end

    sdi_cmd_drive #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_drive (
        .cmd       (cmd),
        .mode_word (mode_word),
        .pins      (pins),
        .addr      (sd_addr)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int N_REF  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_set,
    input logic              init_busy,
    input logic              cpu_stall,
    input logic              init_done,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_cke,
    input logic              sd_udqm,
    input logic              sd_ldqm,
    input logic [ADDR_W-1:0] sd_addr
);
    logic is_pre, is_mrs, is_ref, is_nop;
    logic [7:0] ref_seen_q, mrs_seen_q;

    assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
    assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_seen_q <= '0;
            mrs_seen_q <= '0;
        end else if (is_pre) begin
            ref_seen_q <= '0;
            mrs_seen_q <= '0;
        end else begin
            if (is_ref) ref_seen_q <= ref_seen_q + 1'b1;
            if (is_mrs) mrs_seen_q <= mrs_seen_q + 1'b1;
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_busy && init_set) |=> is_pre);

    assert_all_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[AP_BIT]);

    assert_single_mode_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (mrs_seen_q == 8'd1));

    assert_refresh_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (ref_seen_q == 8'(N_REF)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);

    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!cpu_stall && !init_busy && $past(cpu_stall)));

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && init_set) |=> !is_pre);

    assert_idle_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> (is_nop && sd_addr == '0));

    assert_pins_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke && sd_udqm && sd_ldqm);
endmodule

bind sdram_init_seq sdram_init_chk #(
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .N_REF  (N_REF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_set  (init_set),
    .init_busy (init_busy),
    .cpu_stall (cpu_stall),
    .init_done (init_done),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_cke    (sd_cke),
    .sd_udqm   (sd_udqm),
    .sd_ldqm   (sd_ldqm),
    .sd_addr   (sd_addr)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_set = 1'b0;
    logic [11:0] mode_word = '0;
    logic [3:0]  t_rp = 4'd1, t_mrd = 4'd1, t_rc = 4'd1;
    logic        init_busy, cpu_stall, init_done;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_udqm, sd_ldqm;
    logic [11:0] sd_addr;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    // {mode_word, t_rp, t_mrd, t_rc}
    localparam logic [23:0] VECS [0:NV-1] = '{
        {12'h023, 4'd1, 4'd1, 4'd1},
        {12'h032, 4'd2, 4'd3, 4'd4},
        {12'h0A7, 4'd0, 4'd0, 4'd0},
        {12'h3F1, 4'd5, 4'd2, 4'd1},
        {12'hC55, 4'd15, 4'd1, 4'd3},
        {12'h022, 4'd3, 4'd0, 4'd7}
    };

    always #5 clk = ~clk;

    sdram_init_seq dut (
        .clk(clk), .rst_n(rst_n), .init_set(init_set), .mode_word(mode_word),
        .t_rp(t_rp), .t_mrd(t_mrd), .t_rc(t_rc),
        .init_busy(init_busy), .cpu_stall(cpu_stall), .init_done(init_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_cke(sd_cke), .sd_udqm(sd_udqm), .sd_ldqm(sd_ldqm), .sd_addr(sd_addr)
    );

    function automatic int eff(input logic [3:0] t);
        return (t == 0) ? 1 : int'(t);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    // Run one full train and check every cycle k = 1 .. T+1 against the requirements.
    task automatic run_seq(input logic [23:0] v, input bit started, input int inject_k,
                           input bit chain);
        int p, m, r, tot;
        {mode_word, t_rp, t_mrd, t_rc} = v;
        p = eff(t_rp); m = eff(t_mrd); r = eff(t_rc);
        tot = 2 + p + m + 8 * (1 + r);
        if (!started) begin
            @(negedge clk);
            init_set = 1'b1;
        end
        for (int k = 1; k <= tot + 1; k++) begin
            logic [3:0]  ecmd;
            logic [11:0] eaddr;
            string       tag;
            @(negedge clk);
            ecmd = 4'b0111; eaddr = '0; tag = "R5";
            if (k == 1) begin
                ecmd = 4'b0010; eaddr = 12'h400; tag = "R2";
            end else if (k <= 1 + p) begin
                tag = "R3";
            end else if (k == 2 + p) begin
                ecmd = 4'b0000; eaddr = mode_word; tag = "R3";
            end else if (k <= 2 + p + m) begin
                tag = "R4";
            end else if (k == 3 + p + m) begin
                ecmd = 4'b0001; tag = "R4";
            end else if (k <= tot) begin
                if (((k - (3 + p + m)) % (1 + r)) == 0) ecmd = 4'b0001;
                tag = (v[11:0] == 12'h0A7) ? "R5/R6" : "R5";
            end else begin
                tag = "R8";
            end
            check(tag, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}, {ecmd, eaddr});
            check("R7", {cpu_stall, init_busy}, (k <= tot) ? 2'b11 : 2'b00);
            check("R8", init_done, (k == tot + 1));
            check("R10", {sd_cke, sd_udqm, sd_ldqm}, 3'b111);
            // R9: extra request while busy; R11: request in the done cycle
            init_set = (k == inject_k) || (chain && k == tot + 1);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}, {4'b0111, 12'h000});
        check("R1", {init_busy, cpu_stall, init_done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {init_busy, cpu_stall, init_done}, 3'b000);

        // Table walk; vector 1 gets a mid-train request (R9)
        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i], 1'b0, (i == 1) ? 5 : ((i == 4) ? 30 : 0), 1'b0);
            repeat (2) @(negedge clk);
        end

        // R11: start in the done cycle, then a second full train
        run_seq(VECS[0], 1'b0, 0, 1'b1);
        run_seq(VECS[1], 1'b1, 0, 1'b0);

        // R9: no second train after an ignored request; block stays idle
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R9", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, cpu_stall, init_done},
                  6'b011100);
        end

        summary();
        $finish;
    end
endmodule